// File: doc/BRIEF.md
# Stack Machine Instruction Sequencer

This block is the sequencing and stack core of a very small stack processor. It owns a 16-bit program counter whose value addresses an external combinational program memory. It receives back the word stored at that address each cycle. It holds a two-entry operand stack: a top register and a next register. It decodes each fetched word and applies it to the stack. Arithmetic and logic opcodes are handed to an external function unit, which sees the low six opcode bits and returns its result combinationally.

Four kinds of opcode are decoded:
- Register moves.
- Function-unit operations.
- I/O operations: read eight switches, or strobe a display register with the top value.
- Transfer operations, which occupy two words.

For a transfer, the word after the opcode is a literal or a branch target. Two of the branches test a debounced pushbutton level directly. A program can therefore spin on a single instruction until the button is pressed or released.

A typical program waits for a button press, reads the switches, and shows them on the display. It then computes on the stack and loops back with an unconditional jump.

Top module: `stackSeq`

## Requirements
- R1: An active-high reset asynchronously forces the program counter, top and next registers to zero and returns decoding to the first-word phase.
- R2: On a clock edge the program counter takes the fetched word when the load strobe is high, otherwise adds one when the increment strobe is high; the two strobes are never high together.
- R3: Opcode 0x0000 and every opcode not listed in these requirements only advance the program counter by one; the stack is unchanged.
- R4: Opcode 0x0001 copies top into next with top unchanged; opcode 0x0002 exchanges top and next.
- R5: An opcode in 0x0010..0x002D drives its low six bits on the function code output during its cycle, loads top from the function-unit result and leaves next unchanged; all other cycles drive function code 0.
- R6: Opcode 0x0037 moves top into next and loads top with the eight switch bits, zero-extended.
- R7: Opcode 0x0038 raises the display-load strobe for exactly its own cycle and leaves the stack unchanged.
- R8: A transfer opcode (0x0100, 0x0101, 0x0102, 0x0109, 0x010D) takes two cycles. In the first cycle the program counter advances by one and the stack is unchanged. In the next cycle the fetched word is used as its operand.
- R9: 0x0100 followed by a word pushes that word (old top to next) and leaves the program counter two past the opcode.
- R10: 0x0101 loads the program counter with its operand word.
- R11: 0x0102 loads the program counter with its operand when top is zero, otherwise steps past the operand; in both cases top is popped, taking the value of next.
- R12: 0x010D jumps to its operand while the button input is 1 and 0x0109 jumps while it is 0; otherwise each steps past the operand, and neither changes the stack.
- R13: While an operand word is being consumed, the display-load strobe is low and the function code is 0, whatever that word's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| instrWord | input | 16 | Word read from program memory at pcAddr |
| switches | input | 8 | Switch levels for the fetch opcode |
| button | input | 1 | Debounced pushbutton level, 1 when pressed |
| funcResult | input | 16 | Combinational result of the external function unit |
| pcAddr | output | 16 | Program counter value, the memory address |
| pcLoad | output | 1 | Program counter load strobe for this cycle |
| pcInc | output | 1 | Program counter increment strobe for this cycle |
| funcCode | output | 6 | Function code for the external function unit |
| topVal | output | 16 | Top-of-stack register |
| nextVal | output | 16 | Second stack register |
| digLoad | output | 1 | Display register load strobe |

## Verification
A wrong phase bit is the most damaging fault. An operand word would be decoded as an opcode, or an opcode would be skipped as an operand. This shows on pcAddr and the stack registers one edge later. It also shows at once on digLoad and funcCode when the misread word falls in their ranges.

A wrong stack update shows on topVal or nextVal on the next edge. A wrong branch decision shows on pcAddr on the next edge. In every case the error then spreads through the whole following instruction stream. For that reason, every cycle is compared against a model of the program, not only selected points.

// File: rtl/stackSeqPkg.sv
package stackSeqPkg;

  typedef enum logic [2:0] {
    STK_HOLD,
    STK_PUSH_WORD,
    STK_PUSH_SW,
    STK_FUNC,
    STK_POP,
    STK_SWAP,
    STK_DUP
  } stackOp_e;

  typedef enum logic {
    PH_EXEC,
    PH_OPERAND
  } phase_e;

  typedef struct packed {
    logic     pcLoad;
    logic     pcInc;
    stackOp_e stackOp;
    logic     digLoad;
  } ctrlStrobes_t;

  localparam logic [15:0] OPC_NOP     = 16'h0000;
  localparam logic [15:0] OPC_DUP     = 16'h0001;
  localparam logic [15:0] OPC_SWAP    = 16'h0002;
  localparam logic [15:0] OPC_FUNC_LO = 16'h0010;
  localparam logic [15:0] OPC_FUNC_HI = 16'h002D;
  localparam logic [15:0] OPC_SWREAD  = 16'h0037;
  localparam logic [15:0] OPC_SHOW    = 16'h0038;
  localparam logic [15:0] OPC_LIT     = 16'h0100;
  localparam logic [15:0] OPC_JUMP    = 16'h0101;
  localparam logic [15:0] OPC_JZERO   = 16'h0102;
  localparam logic [15:0] OPC_JBTNLO  = 16'h0109;
  localparam logic [15:0] OPC_JBTNHI  = 16'h010D;

endpackage

// File: rtl/stackSeqCtrl.sv
module stackSeqCtrl
  import stackSeqPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int FC_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] instrWord,
  input  logic              topIsZero,
  input  logic              button,
  output ctrlStrobes_t      strobes,
  output logic [FC_W-1:0]   funcCode
);

  localparam logic [WORD_W-1:0] W_DUP     = WORD_W'(OPC_DUP);
  localparam logic [WORD_W-1:0] W_SWAP    = WORD_W'(OPC_SWAP);
  localparam logic [WORD_W-1:0] W_FUNC_LO = WORD_W'(OPC_FUNC_LO);
  localparam logic [WORD_W-1:0] W_FUNC_HI = WORD_W'(OPC_FUNC_HI);
  localparam logic [WORD_W-1:0] W_SWREAD  = WORD_W'(OPC_SWREAD);
  localparam logic [WORD_W-1:0] W_SHOW    = WORD_W'(OPC_SHOW);
  localparam logic [WORD_W-1:0] W_LIT     = WORD_W'(OPC_LIT);
  localparam logic [WORD_W-1:0] W_JUMP    = WORD_W'(OPC_JUMP);
  localparam logic [WORD_W-1:0] W_JZERO   = WORD_W'(OPC_JZERO);
  localparam logic [WORD_W-1:0] W_JBTNLO  = WORD_W'(OPC_JBTNLO);
  localparam logic [WORD_W-1:0] W_JBTNHI  = WORD_W'(OPC_JBTNHI);

  phase_e            phase;
  phase_e            phaseNext;
  logic [WORD_W-1:0] heldOp;
  logic              isTransfer;
  logic              isFunc;

  always_comb begin
    isTransfer = (instrWord == W_LIT)    || (instrWord == W_JUMP) ||
                 (instrWord == W_JZERO)  || (instrWord == W_JBTNLO) ||
                 (instrWord == W_JBTNHI);
    isFunc     = (instrWord >= W_FUNC_LO) && (instrWord <= W_FUNC_HI);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase  <= PH_EXEC;
      heldOp <= '0;
    end else begin
      phase <= phaseNext;
      if (phase == PH_EXEC && isTransfer) begin
        heldOp <= instrWord;
      end
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.stackOp = STK_HOLD;
    funcCode        = '0;
    phaseNext       = PH_EXEC;
    if (phase == PH_EXEC) begin
      strobes.pcInc = 1'b1;
      if (isFunc) begin
        strobes.stackOp = STK_FUNC;
        funcCode        = instrWord[FC_W-1:0];
      end else if (isTransfer) begin
        phaseNext = PH_OPERAND;
      end else begin
        unique case (instrWord)
          W_DUP:    strobes.stackOp = STK_DUP;
          W_SWAP:   strobes.stackOp = STK_SWAP;
          W_SWREAD: strobes.stackOp = STK_PUSH_SW;
          W_SHOW:   strobes.digLoad = 1'b1;
          default:  strobes.stackOp = STK_HOLD;
        endcase
      end
    end else begin
      unique case (heldOp)
        W_LIT: begin
          strobes.stackOp = STK_PUSH_WORD;
          strobes.pcInc   = 1'b1;
        end
        W_JUMP: begin
          strobes.pcLoad = 1'b1;
        end
        W_JZERO: begin
          strobes.stackOp = STK_POP;
          strobes.pcLoad  = topIsZero;
          strobes.pcInc   = !topIsZero;
        end
        W_JBTNHI: begin
          strobes.pcLoad = button;
          strobes.pcInc  = !button;
        end
        W_JBTNLO: begin
          strobes.pcLoad = !button;
          strobes.pcInc  = button;
        end
        default: begin
          strobes.pcInc = 1'b1;
        end
      endcase
    end
  end

  AST_PC_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(strobes.pcLoad && strobes.pcInc)); // R2

  AST_OPERAND_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    phase == PH_OPERAND |=> phase == PH_EXEC); // R8

  AST_TRANSFER_HOLDS_STACK: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EXEC && isTransfer) |-> strobes.stackOp == STK_HOLD); // R8

  AST_SHOW_NOT_IN_OPERAND: assert property (@(posedge clk) disable iff (rst)
    strobes.digLoad |-> phase == PH_EXEC); // R13

  AST_FCODE_NOT_IN_OPERAND: assert property (@(posedge clk) disable iff (rst)
    phase == PH_OPERAND |-> funcCode == '0); // R13

endmodule

// File: rtl/stackSeqPath.sv
module stackSeqPath
  import stackSeqPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SW_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [WORD_W-1:0] instrWord,
  input  logic [SW_W-1:0]   switches,
  input  logic [WORD_W-1:0] funcResult,
  output logic [WORD_W-1:0] pcAddr,
  output logic [WORD_W-1:0] topVal,
  output logic [WORD_W-1:0] nextVal,
  output logic              topIsZero
);

  localparam logic [WORD_W-1:0] PC_STEP = WORD_W'(1);

  logic [WORD_W-1:0] pcReg;
  logic [WORD_W-1:0] tReg;
  logic [WORD_W-1:0] nReg;
  logic [WORD_W-1:0] swWord;

  assign swWord = WORD_W'(switches);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pcReg <= '0;
    end else if (strobes.pcLoad) begin
      pcReg <= instrWord;
    end else if (strobes.pcInc) begin
      pcReg <= pcReg + PC_STEP;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      tReg <= '0;
      nReg <= '0;
    end else begin
      unique case (strobes.stackOp)
        STK_PUSH_WORD: begin
          nReg <= tReg;
          tReg <= instrWord;
        end
        STK_PUSH_SW: begin
          nReg <= tReg;
          tReg <= swWord;
        end
        STK_FUNC: tReg <= funcResult;
        STK_POP:  tReg <= nReg;
        STK_SWAP: begin
          nReg <= tReg;
          tReg <= nReg;
        end
        STK_DUP:  nReg <= tReg;
        default: ;
      endcase
    end
  end

  assign pcAddr    = pcReg;
  assign topVal    = tReg;
  assign nextVal   = nReg;
  assign topIsZero = (tReg == '0);

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (strobes.pcInc && !strobes.pcLoad) |=> pcReg == $past(pcReg) + PC_STEP); // R2

  AST_PC_LOAD: assert property (@(posedge clk) disable iff (rst)
    strobes.pcLoad |=> pcReg == $past(instrWord)); // R2

  AST_DUP_COPY: assert property (@(posedge clk) disable iff (rst)
    strobes.stackOp == STK_DUP |=> (nReg == $past(tReg) && tReg == $past(tReg))); // R4

  AST_SWAP_EXCHANGE: assert property (@(posedge clk) disable iff (rst)
    strobes.stackOp == STK_SWAP |=> (nReg == $past(tReg) && tReg == $past(nReg))); // R4

  AST_FUNC_KEEPS_NEXT: assert property (@(posedge clk) disable iff (rst)
    strobes.stackOp == STK_FUNC |=> (nReg == $past(nReg) && tReg == $past(funcResult))); // R5

  AST_SWREAD_PUSH: assert property (@(posedge clk) disable iff (rst)
    strobes.stackOp == STK_PUSH_SW |=> (nReg == $past(tReg) && tReg == $past(swWord))); // R6

  AST_POP_TAKES_NEXT: assert property (@(posedge clk) disable iff (rst)
    strobes.stackOp == STK_POP |=> tReg == $past(nReg)); // R11

endmodule

// File: rtl/stackSeq.sv
module stackSeq
  import stackSeqPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SW_W   = 8,
  parameter int FC_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] instrWord,
  input  logic [SW_W-1:0]   switches,
  input  logic              button,
  input  logic [WORD_W-1:0] funcResult,
  output logic [WORD_W-1:0] pcAddr,
  output logic              pcLoad,
  output logic              pcInc,
  output logic [FC_W-1:0]   funcCode,
  output logic [WORD_W-1:0] topVal,
  output logic [WORD_W-1:0] nextVal,
  output logic              digLoad
);

  ctrlStrobes_t strobes;
  logic         topIsZero;

  stackSeqCtrl #(.WORD_W(WORD_W), .FC_W(FC_W)) ctrl (
    .clk       (clk),
    .rst       (rst),
    .instrWord (instrWord),
    .topIsZero (topIsZero),
    .button    (button),
    .strobes   (strobes),
    .funcCode  (funcCode)
  );

  stackSeqPath #(.WORD_W(WORD_W), .SW_W(SW_W)) path (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .instrWord  (instrWord),
    .switches   (switches),
    .funcResult (funcResult),
    .pcAddr     (pcAddr),
    .topVal     (topVal),
    .nextVal    (nextVal),
    .topIsZero  (topIsZero)
  );

  assign pcLoad  = strobes.pcLoad;
  assign pcInc   = strobes.pcInc;
  assign digLoad = strobes.digLoad;

endmodule

// File: tb/stackSeq_test.sv
module stackSeq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] instrWord;
  logic [7:0]  switches;
  logic        button;
  logic [15:0] funcResult;
  logic [15:0] pcAddr;
  logic        pcLoad;
  logic        pcInc;
  logic [5:0]  funcCode;
  logic [15:0] topVal;
  logic [15:0] nextVal;
  logic        digLoad;

  logic [15:0] progMem [64];

  typedef struct {
    logic [15:0] pc;
    logic [15:0] t;
    logic [15:0] n;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] mPc, mT, mN, mOp;
  bit          mOperand;

  stackSeq uut (
    .clk(clk), .rst(rst), .instrWord(instrWord), .switches(switches),
    .button(button), .funcResult(funcResult), .pcAddr(pcAddr),
    .pcLoad(pcLoad), .pcInc(pcInc), .funcCode(funcCode),
    .topVal(topVal), .nextVal(nextVal), .digLoad(digLoad)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb instrWord = progMem[pcAddr[5:0]];

  // stand-in function unit
  assign funcResult = (topVal ^ {nextVal[7:0], nextVal[15:8]}) + {10'd0, funcCode};

  task automatic checkVal(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mPc = 16'h0; mT = 16'h0; mN = 16'h0; mOp = 16'h0; mOperand = 0;
  endtask

  // driver: checks this cycle's strobes, pushes the state expected after the edge
  task automatic modelStep();
    logic [15:0] w, nPc, nT, nN;
    logic        expDig, expLd, expInc, nOperand;
    logic [5:0]  expFc;
    string       tag, strobeTag;
    expItem_t    item;
    w = progMem[mPc[5:0]];
    expDig = 0; expFc = 6'd0; expLd = 0; expInc = 0; nOperand = 0;
    tag = "R3"; nPc = mPc; nT = mT; nN = mN;
    if (!mOperand) begin
      expInc = 1;
      if (w >= 16'h0010 && w <= 16'h002D) begin
        tag = "R5"; expFc = w[5:0];
        nT = (mT ^ {mN[7:0], mN[15:8]}) + {10'd0, expFc};
      end else begin
        case (w)
          16'h0001: begin tag = "R4"; nN = mT; end
          16'h0002: begin tag = "R4"; nN = mT; nT = mN; end
          16'h0037: begin tag = "R6"; nN = mT; nT = {8'd0, switches}; end
          16'h0038: begin tag = "R7"; expDig = 1; end
          16'h0100, 16'h0101, 16'h0102, 16'h0109, 16'h010D: begin
            tag = "R8"; nOperand = 1; mOp = w;
          end
          default: ;
        endcase
      end
      strobeTag = tag;
    end else begin
      strobeTag = "R13";
      case (mOp)
        16'h0100: begin tag = "R9"; nN = mT; nT = w; expInc = 1; end
        16'h0101: begin tag = "R10"; expLd = 1; end
        16'h0102: begin tag = "R11"; nT = mN; expLd = (mT == 16'h0); expInc = !expLd; end
        16'h010D: begin tag = "R12"; expLd = button; expInc = !button; end
        16'h0109: begin tag = "R12"; expLd = !button; expInc = button; end
        default:  begin expInc = 1; end
      endcase
    end
    if (expLd) nPc = w;
    else if (expInc) nPc = mPc + 16'd1;
    checkVal(strobeTag, "digLoad", {15'd0, digLoad}, {15'd0, expDig});
    checkVal(strobeTag, "funcCode", {10'd0, funcCode}, {10'd0, expFc});
    checkVal("R2", "pcLoad", {15'd0, pcLoad}, {15'd0, expLd});
    checkVal("R2", "pcInc", {15'd0, pcInc}, {15'd0, expInc});
    item.pc = nPc; item.t = nT; item.n = nN; item.tag = tag;
    expQ.push_back(item);
    mPc = nPc; mT = nT; mN = nN; mOperand = nOperand;
  endtask

  task automatic runCycles(int n);
    for (int i = 0; i < n; i++) begin
      #1;
      modelStep();
      @(negedge clk);
    end
  endtask

  // monitor: compares state after each edge with the scoreboard
  always @(negedge clk) begin
    expItem_t e;
    if (expQ.size() != 0) begin
      e = expQ.pop_front();
      checkVal(e.tag, "pcAddr", pcAddr, e.pc);
      checkVal(e.tag, "topVal", topVal, e.t);
      checkVal(e.tag, "nextVal", nextVal, e.n);
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (R8 sequencing): actual hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) progMem[i] = 16'h0000;
    progMem[0]  = 16'h0037;                       // read switches
    progMem[1]  = 16'h0001;                       // dup
    progMem[2]  = 16'h0100; progMem[3]  = 16'h1234; // literal
    progMem[4]  = 16'h0002;                       // swap
    progMem[5]  = 16'h0010;                       // function, low end
    progMem[6]  = 16'h001A;                       // function
    progMem[7]  = 16'h0038;                       // display
    progMem[8]  = 16'h0055;                       // unknown opcode
    progMem[9]  = 16'h010D; progMem[10] = 16'h0009; // wait while pressed
    progMem[11] = 16'h0109; progMem[12] = 16'h000B; // wait while released
    progMem[13] = 16'h0102; progMem[14] = 16'h0014; // jz
    progMem[15] = 16'h0100; progMem[16] = 16'h0000; // literal zero
    progMem[17] = 16'h0102; progMem[18] = 16'h0014; // jz, taken
    progMem[19] = 16'h0001;                       // skipped
    progMem[20] = 16'h002D;                       // function, high end
    progMem[21] = 16'h0037;
    progMem[22] = 16'h0100; progMem[23] = 16'h0038; // operand looks like display
    progMem[24] = 16'h0101; progMem[25] = 16'h0000; // jump to start

    rst = 1'b1; button = 1'b1; switches = 8'h3B;
    #(CLK_PERIOD * 2 + 3);
    checkVal("R1", "pcAddr at reset", pcAddr, 16'h0);
    checkVal("R1", "topVal at reset", topVal, 16'h0);
    checkVal("R1", "nextVal at reset", nextVal, 16'h0);
    @(negedge clk);
    rst = 1'b0;
    modelReset();
    runCycles(30);
    button = 1'b0;
    runCycles(12);
    button = 1'b1; switches = 8'hA5;
    runCycles(60);
    button = 1'b0;
    runCycles(20);
    button = 1'b1; switches = 8'h00;
    runCycles(40);

    // asynchronous reset in mid-run
    #3;
    rst = 1'b1;
    #1;
    checkVal("R1", "pcAddr async reset", pcAddr, 16'h0);
    checkVal("R1", "topVal async reset", topVal, 16'h0);
    checkVal("R1", "nextVal async reset", nextVal, 16'h0);
    expQ.delete();
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelReset();
    switches = 8'h7E; button = 1'b0;
    runCycles(25);
    button = 1'b1;
    runCycles(30);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule